// File: doc/BRIEF.md
# SMBus host controller register front end

This block is the register file a processor sees when it drives an SMBus master. Software loads a command byte, a target address with the direction in its low bit, two data bytes and, for block transfers, a 32-byte buffer. It then writes the control register with the start bit set. The front end decodes the protocol field and raises one request toward an external bus engine, which does the wire-level work. When the engine acknowledges, the front end captures any returned data.

The block buffer is reached through one byte register with a single auto-incrementing index. Reads and writes share that index. It is cleared by any write to the status register or any read of the control register. While a block read is in flight, the engine fills the buffer through its own write port. During a block write, the engine reads the buffer through a random-access read port.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every host register reads 0x00 and `eng_req` is low.
- R2: Host reads return status at offset 0, control at 2, command at 3, address at 4, data0 at 5, data1 at 6 and the buffer byte at 7. Offset 1 and every offset above 7 read 0x00. Control reads return only bits 4:0, with bits 7:5 read as 0.
- R3: A host write to offset 2 with bit 6 set and bits 4:2 equal to 0, 1, 2, 3 or 5 raises `eng_req` after that edge. The request presents: the protocol from bits 4:2, the target from address bits 7:1, `eng_read` from address bit 0, the command, data0 and data1.
- R4: A start whose protocol field is 4, 6 or 7 raises no request and sets status bit 2.
- R5: `eng_req` and its fields hold until `eng_ack` and fall at the acking edge. For read directions, the ack loads data as follows:
  - protocols 1, 2 and 5 load `eng_rdata0` into data0;
  - protocol 3 loads data0 from `eng_rdata0` (low byte) and data1 from `eng_rdata1` (high byte).
  - Write directions and protocol 0 leave both data bytes unchanged.
- R6: A start written while `eng_req` is high is ignored: the request fields stay as they were, and no second request follows the ack.
- R7: Each host access to offset 7 reads or writes the buffer entry at the index, then advances the index. After entry 31 the index wraps to 0.
- R8: Any host write to offset 0 clears the whole status byte and resets the buffer index to 0.
- R9: A host read of offset 2 resets the buffer index to 0.
- R10: While `eng_req` is high, `eng_blk_we` writes `eng_blk_wdata` into buffer entry `eng_blk_widx`.
- R11: `eng_blk_rbyte` always shows buffer entry `eng_blk_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current offset |
| eng_req | output | 1 | Transaction request to the bus engine |
| eng_proto | output | 3 | Protocol code of the request |
| eng_target | output | 7 | Target device address |
| eng_read | output | 1 | 1 for a read transaction |
| eng_cmd | output | 8 | Command byte |
| eng_wdata0 | output | 8 | Data0 (low byte, or block count) |
| eng_wdata1 | output | 8 | Data1 (high byte) |
| eng_ack | input | 1 | Engine completion |
| eng_rdata0 | input | 8 | Returned low byte or block count |
| eng_rdata1 | input | 8 | Returned high byte |
| eng_blk_idx | input | log2(DEPTH) | Buffer read index for the engine |
| eng_blk_rbyte | output | 8 | Buffer entry at eng_blk_idx |
| eng_blk_we | input | 1 | Engine buffer write enable |
| eng_blk_widx | input | log2(DEPTH) | Engine buffer write index |
| eng_blk_wdata | input | 8 | Engine buffer write byte |

## Verification
A corrupted buffer index shows up at the first read of offset 7, as a byte from the wrong entry. It also shows when the index reset is missed after a status write or control read. A lost or stuck pending flag shows on `eng_req` in the very next cycle, because the bench compares the request line with its model on every clock. A wrong capture on ack appears at the next read of data0 or data1. Sequences that wrap the index past 32 and write a start while busy expose the off-by-one and missing-guard cases.

// File: rtl/smbus_host_regs.sv
module smbus_host_regs #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_en,
  input  logic                     host_wr,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     eng_req,
  output logic [2:0]               eng_proto,
  output logic [6:0]               eng_target,
  output logic                     eng_read,
  output logic [7:0]               eng_cmd,
  output logic [7:0]               eng_wdata0,
  output logic [7:0]               eng_wdata1,
  input  logic                     eng_ack,
  input  logic [7:0]               eng_rdata0,
  input  logic [7:0]               eng_rdata1,
  input  logic [$clog2(DEPTH)-1:0] eng_blk_idx,
  output logic [7:0]               eng_blk_rbyte,
  input  logic                     eng_blk_we,
  input  logic [$clog2(DEPTH)-1:0] eng_blk_widx,
  input  logic [7:0]               eng_blk_wdata
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [7:0] stat_q, ctl_q, cmd_q, adr_q, d0_q, d1_q;
  logic [7:0] buf_q [DEPTH];
  logic [IW-1:0] idx_q;
  logic       req_q, rr_q;
  logic [2:0] rp_q;
  logic [6:0] rt_q;
  logic [7:0] rc_q, rw0_q, rw1_q;

  logic       in_map, wr_hit, rd_hit, start, proto_ok;
  logic [2:0] off;
  logic [2:0] new_proto;

  assign in_map    = (host_addr >> 3) == '0;
  assign off       = host_addr[2:0];
  assign wr_hit    = host_en & host_wr & in_map;
  assign rd_hit    = host_en & ~host_wr & in_map;
  assign new_proto = host_wdata[4:2];
  assign start     = wr_hit && off == 3'd2 && host_wdata[6] && !req_q;
  assign proto_ok  = new_proto inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5};

  assign eng_req       = req_q;
  assign eng_proto     = rp_q;
  assign eng_target    = rt_q;
  assign eng_read      = rr_q;
  assign eng_cmd       = rc_q;
  assign eng_wdata0    = rw0_q;
  assign eng_wdata1    = rw1_q;
  assign eng_blk_rbyte = buf_q[eng_blk_idx];

  always_comb begin
    host_rdata = 8'h00;
    if (in_map) begin
      case (off)
        3'd0: host_rdata = stat_q;
        3'd2: host_rdata = {3'b000, ctl_q[4:0]};
        3'd3: host_rdata = cmd_q;
        3'd4: host_rdata = adr_q;
        3'd5: host_rdata = d0_q;
        3'd6: host_rdata = d1_q;
        3'd7: host_rdata = buf_q[idx_q];
        default: host_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; ctl_q <= '0; cmd_q <= '0; adr_q <= '0;
      d0_q <= '0; d1_q <= '0; idx_q <= '0;
      req_q <= 1'b0; rr_q <= 1'b0; rp_q <= '0; rt_q <= '0;
      rc_q <= '0; rw0_q <= '0; rw1_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (req_q && eng_ack) begin
        req_q <= 1'b0;
        if (rr_q) begin
          case (rp_q)
            3'd1, 3'd2, 3'd5: d0_q <= eng_rdata0;
            3'd3: begin d0_q <= eng_rdata0; d1_q <= eng_rdata1; end
            default: ;
          endcase
        end
      end
      if (req_q && eng_blk_we) buf_q[eng_blk_widx] <= eng_blk_wdata;

      if (wr_hit) begin
        case (off)
          3'd0: begin stat_q <= '0; idx_q <= '0; end
          3'd2: ctl_q <= host_wdata;
          3'd3: cmd_q <= host_wdata;
          3'd4: adr_q <= host_wdata;
          3'd5: d0_q <= host_wdata;
          3'd6: d1_q <= host_wdata;
          3'd7: begin
            buf_q[idx_q] <= host_wdata;
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          end
          default: ;
        endcase
      end
      if (rd_hit && off == 3'd2) idx_q <= '0;
      if (rd_hit && off == 3'd7) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;

      if (start) begin
        if (proto_ok) begin
          req_q <= 1'b1;
          rp_q  <= new_proto;
          rt_q  <= adr_q[7:1];
          rr_q  <= adr_q[0];
          rc_q  <= cmd_q;
          rw0_q <= d0_q;
          rw1_q <= d1_q;
        end else begin
          stat_q[2] <= 1'b1;
        end
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_proto) && $stable(eng_target) && $stable(eng_cmd));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_ack |=> !eng_req);

  // R4
  bad_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && host_wr && host_addr == ADDR_W'(2) && host_wdata[6] && !eng_req &&
     host_wdata[4:2] inside {3'd4, 3'd6, 3'd7}) |=> !eng_req && stat_q[2]);

  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && host_wr && host_addr == '0) |=> stat_q == '0 && idx_q == '0);

  // R6
  busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack && host_en && host_wr && host_addr == ADDR_W'(2)) |=>
      eng_req && $stable(eng_read) && $stable(eng_wdata0));
endmodule

// File: tb/smbus_host_regs_tb_top.sv
module smbus_host_regs_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic host_en = 0, host_wr = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic eng_req, eng_read;
  logic [2:0] eng_proto;
  logic [6:0] eng_target;
  logic [7:0] eng_cmd, eng_wdata0, eng_wdata1, eng_blk_rbyte;
  logic eng_ack = 0, eng_blk_we = 0;
  logic [7:0] eng_rdata0 = '0, eng_rdata1 = '0, eng_blk_wdata = '0;
  logic [4:0] eng_blk_idx = '0, eng_blk_widx = '0;

  int n_chk = 0, n_err = 0;
  bit m_req = 0, running = 0;
  int m_buf[32];
  int m_idx = 0;

  always #(PERIOD/2) clk = ~clk;

  smbus_host_regs #(.ADDR_W(AW), .DEPTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_proto(eng_proto), .eng_target(eng_target),
    .eng_read(eng_read), .eng_cmd(eng_cmd), .eng_wdata0(eng_wdata0),
    .eng_wdata1(eng_wdata1), .eng_ack(eng_ack), .eng_rdata0(eng_rdata0),
    .eng_rdata1(eng_rdata1), .eng_blk_idx(eng_blk_idx), .eng_blk_rbyte(eng_blk_rbyte),
    .eng_blk_we(eng_blk_we), .eng_blk_widx(eng_blk_widx), .eng_blk_wdata(eng_blk_wdata));

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (running) chk("R3/R5 req per cycle", int'(eng_req), int'(m_req));
  end

  task automatic wr(input int a, input int d);
    host_en = 1; host_wr = 1; host_addr = AW'(a); host_wdata = 8'(d);
    if (a == 0) m_idx = 0;
    if (a == 7) begin m_buf[m_idx] = d & 8'hff; m_idx = (m_idx + 1) % 32; end
    if (a == 2 && d[6] && !m_req && (d[4:2] inside {0, 1, 2, 3, 5})) m_req = 1;
    @(negedge clk);
    host_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    host_en = 1; host_wr = 0; host_addr = AW'(a);
    #1 d = int'(host_rdata);
    if (a == 2) m_idx = 0;
    if (a == 7) m_idx = (m_idx + 1) % 32;
    @(negedge clk);
    host_en = 0;
  endtask

  task automatic ack(input int r0, input int r1);
    eng_ack = 1; eng_rdata0 = 8'(r0); eng_rdata1 = 8'(r1);
    m_req = 0;
    @(negedge clk);
    eng_ack = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int v;
    for (int i = 0; i < 32; i++) m_buf[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    running = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reset reg", v, 0); end
    chk("R1 req low", int'(eng_req), 0);

    // R2 register map
    wr(3, 8'h5A); wr(4, 8'hA4); wr(5, 8'h11); wr(6, 8'h22);
    rd(3, v); chk("R2 cmd", v, 8'h5A);
    rd(4, v); chk("R2 addr", v, 8'hA4);
    rd(5, v); chk("R2 data0", v, 8'h11);
    rd(6, v); chk("R2 data1", v, 8'h22);
    rd(1, v); chk("R2 offset1", v, 0);
    rd(9, v); chk("R2 offset9", v, 0);

    // R3 word write start
    wr(2, 8'hEC);
    chk("R3 proto", int'(eng_proto), 3);
    chk("R3 target", int'(eng_target), 8'h52);
    chk("R3 dir", int'(eng_read), 0);
    chk("R3 cmd", int'(eng_cmd), 8'h5A);
    chk("R3 wdata0", int'(eng_wdata0), 8'h11);
    chk("R3 wdata1", int'(eng_wdata1), 8'h22);
    rd(2, v); chk("R2 ctl masked", v, 8'h0C);
    // R6 start while busy
    wr(5, 8'h99);
    wr(2, 8'h48);
    chk("R6 proto held", int'(eng_proto), 3);
    chk("R6 wdata0 held", int'(eng_wdata0), 8'h11);
    repeat (2) @(negedge clk);
    chk("R5 req held", int'(eng_req), 1);
    ack(8'hEE, 8'hEE);
    rd(5, v); chk("R5 write keeps data0", v, 8'h99);
    rd(6, v); chk("R5 write keeps data1", v, 8'h22);
    repeat (2) @(negedge clk);
    chk("R6 no second req", int'(eng_req), 0);

    // R5 word read
    wr(4, 8'hA5); wr(2, 8'h4C);
    chk("R3 read dir", int'(eng_read), 1);
    ack(8'h34, 8'h12);
    rd(5, v); chk("R5 word low", v, 8'h34);
    rd(6, v); chk("R5 word high", v, 8'h12);
    // R5 byte-data read
    wr(2, 8'h48);
    chk("R3 proto2", int'(eng_proto), 2);
    ack(8'h77, 8'h55);
    rd(5, v); chk("R5 byte data0", v, 8'h77);
    rd(6, v); chk("R5 byte keeps data1", v, 8'h12);
    // R5 quick
    wr(2, 8'h40);
    chk("R3 proto0", int'(eng_proto), 0);
    ack(8'h01, 8'h02);
    rd(5, v); chk("R5 quick keeps data0", v, 8'h77);

    // R4 bad protocols
    wr(2, 8'h50);
    chk("R4 no req p4", int'(eng_req), 0);
    rd(0, v); chk("R4 status err", v, 8'h04);
    wr(0, 8'h00);
    rd(0, v); chk("R8 status cleared", v, 0);
    wr(2, 8'h58); rd(0, v); chk("R4 status p6", v, 8'h04);
    wr(0, 8'hFF);
    wr(2, 8'h5C); rd(0, v); chk("R4 status p7", v, 8'h04);
    wr(0, 8'h00);

    // R7 buffer wrap
    for (int k = 0; k < 33; k++) wr(7, k * 3 + 1);
    rd(2, v);
    for (int k = 0; k < 32; k++) begin rd(7, v); chk("R7 R9 buffer read", v, m_buf[k]); end
    rd(7, v); chk("R7 wrap read", v, m_buf[0]);
    chk("R7 entry0 overwritten", m_buf[0], 97);
    rd(7, v);
    wr(0, 0);
    rd(7, v); chk("R8 idx reset", v, m_buf[0]);
    rd(2, v);
    rd(7, v); chk("R9 idx reset", v, m_buf[0]);

    // R11 block write with engine read port
    wr(5, 4); wr(4, 8'hA4); wr(2, 8'h54);
    chk("R3 proto5", int'(eng_proto), 5);
    chk("R3 block count", int'(eng_wdata0), 4);
    eng_blk_idx = 5'd2; #1;
    chk("R11 engine read", int'(eng_blk_rbyte), m_buf[2]);
    eng_blk_idx = 5'd31; #1;
    chk("R11 engine read 31", int'(eng_blk_rbyte), m_buf[31]);
    @(negedge clk);
    ack(0, 0);

    // R10 block read
    wr(4, 8'hA5); wr(2, 8'h54);
    for (int k = 0; k < 4; k++) begin
      eng_blk_we = 1; eng_blk_widx = 5'(k); eng_blk_wdata = 8'(8'hB0 + k);
      m_buf[k] = 8'hB0 + k;
      @(negedge clk);
      eng_blk_we = 0;
    end
    ack(4, 0);
    rd(5, v); chk("R5 block count", v, 4);
    wr(0, 0);
    for (int k = 0; k < 4; k++) begin rd(7, v); chk("R10 block bytes", v, 8'hB0 + k); end
    // R10 engine writes ignored when idle
    eng_blk_we = 1; eng_blk_widx = 5'd0; eng_blk_wdata = 8'h3C;
    @(negedge clk);
    eng_blk_we = 0;
    rd(2, v); rd(7, v); chk("R10 idle write ignored", v, 8'hB0);

    @(negedge clk);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule